// File: doc/BRIEF.md
# Radio Controller Control and Status Word

This block is one 32-bit control and status word for a low-energy radio controller. It sits on a plain synchronous register bus with a write strobe, write data and an always-valid read data bus. The word holds configuration fields that software owns and status flags that hardware sets and that stay set until software clears them.

Two error sources feed an error interrupt. The first is a flag for exchange-memory mapping misses, which has its own mask and a separate acknowledge bit. The second is a shared flag for protocol and physical-layer errors, which has active-low enables. The block also watches a slow, asynchronous low-power clock. It synchronizes that clock and records each rising edge in a monitor bit. From the same edges it runs a short sequence after a deep-sleep request that grants radio power-down. It also delivers an 8-bit received-signal-strength byte, taken from either a peak-hold or an averaged 10-bit measurement.

The radio core, the memory mapper and the power sequencer are outside the block. They appear only as input strobes.

Top module: `rfc_csr`

## Requirements
- R1: Out of reset the word reads 0x00000004, which means the mapping-miss mask (bit 2) is on and every other bit is 0. `err_irq` is 0 and `rssi_byte` is 0x00.
- R2: A `memmap_miss` strobe sets bit 0 one cycle later. Writing 1 to bit 1 clears bit 0, and writing 0 to bit 1 leaves it unchanged. Bit 1 always reads 0. Software cannot write bit 0 directly. If a miss and an acknowledge arrive in the same cycle, bit 0 ends up 1.
- R3: `err_irq` is 1 exactly when bit 0 and bit 2 are both 1, or when bit 22 is 1.
- R4: Bit 22 becomes 1 one cycle after `proto_err` while bit 23 is 1, or after `phy_err` while bit 24 is 1. A bit-23 or bit-24 value of 0 blocks that source. Writing 1 to bit 22 clears it. A set in the same cycle as the clear wins.
- R5: `lp_clk` passes through a two-flop synchronizer. Bit 7 becomes 1 on the third bus-clock edge after `lp_clk` rises. Writing 0 to bit 7 clears it, and writing 1 has no effect. A detected edge in the same cycle as a write of 0 leaves bit 7 at 1.
- R6: While `lp_timer_rst` is 1, rising edges of `lp_clk` do not set bit 7.
- R7: After a `sleep_req` strobe, bit 8 becomes 1 together with the second detected low-power rising edge. A `sleep_exit` strobe clears bit 8 one cycle later. Software cannot write bit 8.
- R8: `rssi_byte` is registered. It carries bits [9:2] of `rssi_peak` when bit 21 is 0 and bits [9:2] of `rssi_avg` when bit 21 is 1.
- R9: Bits 2, 3, 14:9 (the master clock frequency in MHz), 17, 18, 19, 21, 23 and 24 are read/write. Bit 6 reads the value of `core_on_master` from one cycle earlier (0 means low-power clock, 1 means master clock).
- R10: Bits 31:25, 20, 16, 15, 5 and 4 always read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current contents of the word |
| memmap_miss | input | 1 | Exchange-memory access hit an unmapped page |
| proto_err | input | 1 | Protocol-engine error strobe |
| phy_err | input | 1 | Physical-layer error strobe |
| lp_clk | input | 1 | Asynchronous low-power clock |
| lp_timer_rst | input | 1 | Low-power timer held in reset; suppresses edge detection |
| sleep_req | input | 1 | Deep-sleep request strobe |
| sleep_exit | input | 1 | Core left sleep (sleep interrupt) |
| core_on_master | input | 1 | Core currently runs on the master clock |
| rssi_peak | input | 10 | Peak-hold signal-strength measurement |
| rssi_avg | input | 10 | Averaged signal-strength measurement |
| rssi_byte | output | 8 | Selected signal-strength byte |
| err_irq | output | 1 | Error interrupt |

## Verification
The bench targets the same-cycle collisions, where a hardware set lands in the same cycle as a software clear on bit 0, bit 22 or bit 7. A design that lets software win in those cycles loses an error or an edge. It also checks that an acknowledge or clear written as 0 changes nothing, so a design that treats these bits as plain read/write would wipe its status. Other tests count the synchronizer latency to the exact cycle and show that masked error sources and edges during timer reset leave no trace. They also check that the power-down grant waits for the second low-power edge, not the first.

// File: rtl/rfc_csr_pkg.sv
package rfc_csr_pkg;

  localparam int WORD_W        = 32;
  localparam int B_MISS_STAT   = 0;
  localparam int B_MISS_ACK    = 1;
  localparam int B_MISS_MSK    = 2;
  localparam int B_DIAG        = 3;
  localparam int B_CLK_STAT    = 6;
  localparam int B_LP_MON      = 7;
  localparam int B_PD_OK       = 8;
  localparam int CLKF_LSB      = 9;
  localparam int CLKF_W        = 6;
  localparam int B_AUX_LSB     = 17;
  localparam int AUX_W         = 3;
  localparam int B_RSSI_SEL    = 21;
  localparam int B_LINK_STAT   = 22;
  localparam int B_PROTO_EN    = 23;
  localparam int B_PHY_EN      = 24;

  localparam logic [WORD_W-1:0] RW_MASK =
      (WORD_W'(1) << B_MISS_MSK) | (WORD_W'(1) << B_DIAG) |
      (WORD_W'((1 << CLKF_W) - 1) << CLKF_LSB) |
      (WORD_W'((1 << AUX_W) - 1) << B_AUX_LSB) |
      (WORD_W'(1) << B_RSSI_SEL) | (WORD_W'(1) << B_PROTO_EN) |
      (WORD_W'(1) << B_PHY_EN);

  localparam logic [WORD_W-1:0] RST_VALUE = WORD_W'(1) << B_MISS_MSK;

  localparam logic [WORD_W-1:0] RSV_MASK =
      ~(RW_MASK | (WORD_W'(1) << B_MISS_STAT) | (WORD_W'(1) << B_MISS_ACK) |
        (WORD_W'(1) << B_CLK_STAT) | (WORD_W'(1) << B_LP_MON) |
        (WORD_W'(1) << B_PD_OK) | (WORD_W'(1) << B_LINK_STAT));

  typedef enum logic [1:0] {
    ST_MISS = 2'd0,
    ST_LINK = 2'd1,
    ST_LPMON = 2'd2
  } sticky_idx_e;

  localparam int N_STICKY = 3;

  typedef enum logic [1:0] {
    PD_IDLE  = 2'd0,
    PD_COUNT = 2'd1,
    PD_GRANT = 2'd2
  } pd_state_e;

endpackage

// File: rtl/rfc_sticky_bit.sv
module rfc_sticky_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // A hardware set outranks a software clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/rfc_lp_edge_mon.sv
module rfc_lp_edge_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic lp_clk,
  input  logic hold_i,
  output logic edge_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], lp_clk};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign edge_o = sync_q[SYNC_STAGES-1] & ~prev_q & ~hold_i;
endmodule

// File: rtl/rfc_pd_seq.sv
module rfc_pd_seq
  import rfc_csr_pkg::*;
#(
  parameter int PD_LP_EDGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic exit_i,
  input  logic edge_i,
  output logic grant_o
);
  localparam int CW = (PD_LP_EDGES < 2) ? 1 : $clog2(PD_LP_EDGES);
  localparam logic [CW-1:0] LAST = CW'(PD_LP_EDGES - 1);

  pd_state_e      state_q;
  logic [CW-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (rst || exit_i) begin
      state_q <= PD_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        PD_IDLE: if (req_i) begin
          state_q <= PD_COUNT;
          cnt_q   <= '0;
        end
        PD_COUNT: if (edge_i) begin
          if (cnt_q == LAST) state_q <= PD_GRANT;
          else               cnt_q   <= cnt_q + CW'(1);
        end
        PD_GRANT: state_q <= PD_GRANT;
        default:  state_q <= PD_IDLE;
      endcase
    end
  end

  assign grant_o = (state_q == PD_GRANT);
endmodule

// File: rtl/rfc_csr.sv
module rfc_csr
  import rfc_csr_pkg::*;
#(
  parameter int RSSI_W      = 10,
  parameter int SYNC_STAGES = 2,
  parameter int PD_LP_EDGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic              memmap_miss,
  input  logic              proto_err,
  input  logic              phy_err,
  input  logic              lp_clk,
  input  logic              lp_timer_rst,
  input  logic              sleep_req,
  input  logic              sleep_exit,
  input  logic              core_on_master,
  input  logic [RSSI_W-1:0] rssi_peak,
  input  logic [RSSI_W-1:0] rssi_avg,
  output logic [7:0]        rssi_byte,
  output logic              err_irq
);
  localparam int RSSI_LSB = RSSI_W - 8;

  logic [WORD_W-1:0]   cfg_q;
  logic [N_STICKY-1:0] st_set, st_clr, st_q;
  logic                lp_edge, pd_grant, clk_stat_q;
  logic                rssi_lsb_unused;

  // Software-owned fields
  always_ff @(posedge clk) begin
    if (rst)        cfg_q <= RST_VALUE & RW_MASK;
    else if (wr_en) cfg_q <= wr_data & RW_MASK;
  end

  // Hardware-set flags
  always_comb begin
    st_set[ST_MISS]  = memmap_miss;
    st_clr[ST_MISS]  = wr_en & wr_data[B_MISS_ACK];
    st_set[ST_LINK]  = (proto_err & cfg_q[B_PROTO_EN]) | (phy_err & cfg_q[B_PHY_EN]);
    st_clr[ST_LINK]  = wr_en & wr_data[B_LINK_STAT];
    st_set[ST_LPMON] = lp_edge;
    st_clr[ST_LPMON] = wr_en & ~wr_data[B_LP_MON];
  end

  for (genvar i = 0; i < N_STICKY; i++) begin : g_sticky
    rfc_sticky_bit u_bit (
      .clk   (clk),
      .rst   (rst),
      .set_i (st_set[i]),
      .clr_i (st_clr[i]),
      .q_o   (st_q[i])
    );
  end

  rfc_lp_edge_mon #(.SYNC_STAGES(SYNC_STAGES)) u_lpmon (
    .clk    (clk),
    .rst    (rst),
    .lp_clk (lp_clk),
    .hold_i (lp_timer_rst),
    .edge_o (lp_edge)
  );

  rfc_pd_seq #(.PD_LP_EDGES(PD_LP_EDGES)) u_pd (
    .clk     (clk),
    .rst     (rst),
    .req_i   (sleep_req),
    .exit_i  (sleep_exit),
    .edge_i  (lp_edge),
    .grant_o (pd_grant)
  );

  // Status sample and signal-strength byte
  always_ff @(posedge clk) begin
    if (rst) begin
      clk_stat_q <= 1'b0;
      rssi_byte  <= '0;
    end else begin
      clk_stat_q <= core_on_master;
      rssi_byte  <= cfg_q[B_RSSI_SEL] ? rssi_avg[RSSI_W-1:RSSI_LSB]
                                      : rssi_peak[RSSI_W-1:RSSI_LSB];
    end
  end

  assign rssi_lsb_unused = ^{rssi_peak[RSSI_LSB-1:0], rssi_avg[RSSI_LSB-1:0]};

  // Read image, built only from flops
  always_comb begin
    rd_data              = cfg_q;
    rd_data[B_MISS_STAT] = st_q[ST_MISS];
    rd_data[B_LINK_STAT] = st_q[ST_LINK];
    rd_data[B_LP_MON]    = st_q[ST_LPMON];
    rd_data[B_CLK_STAT]  = clk_stat_q;
    rd_data[B_PD_OK]     = pd_grant;
  end

  assign err_irq = (st_q[ST_MISS] & cfg_q[B_MISS_MSK]) | st_q[ST_LINK];
endmodule

// File: rtl/rfc_csr_chk.sv
module rfc_csr_chk
  import rfc_csr_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        memmap_miss,
  input logic        proto_err,
  input logic        phy_err,
  input logic        sleep_exit,
  input logic        err_irq
);
  // R2
  miss_sets_stat_chk: assert property (@(posedge clk) disable iff (rst)
    memmap_miss |=> rd_data[B_MISS_STAT]);

  // R2
  ack_zero_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[B_MISS_ACK] && rd_data[B_MISS_STAT]) |=> rd_data[B_MISS_STAT]);

  // R3
  irq_from_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data[B_MISS_STAT] && rd_data[B_MISS_MSK]) |-> err_irq);

  // R3
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_data[B_MISS_STAT] && !rd_data[B_LINK_STAT]) |-> !err_irq);

  // R4
  proto_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (proto_err && rd_data[B_PROTO_EN]) |=> rd_data[B_LINK_STAT]);

  // R4
  link_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_data[B_LINK_STAT] && !(proto_err && rd_data[B_PROTO_EN]) &&
     !(phy_err && rd_data[B_PHY_EN])) |=> !rd_data[B_LINK_STAT]);

  // R7
  exit_clears_pd_chk: assert property (@(posedge clk) disable iff (rst)
    sleep_exit |=> !rd_data[B_PD_OK]);

  // R10
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data & RSV_MASK) == '0);
endmodule

bind rfc_csr rfc_csr_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .rd_data     (rd_data),
  .memmap_miss (memmap_miss),
  .proto_err   (proto_err),
  .phy_err     (phy_err),
  .sleep_exit  (sleep_exit),
  .err_irq     (err_irq)
);

// File: tb/rfc_csr_bench.sv
`timescale 1ns/1ps
module rfc_csr_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        memmap_miss = 1'b0, proto_err = 1'b0, phy_err = 1'b0;
  logic        lp_clk = 1'b0, lp_timer_rst = 1'b0;
  logic        sleep_req = 1'b0, sleep_exit = 1'b0, core_on_master = 1'b0;
  logic [9:0]  rssi_peak = '0, rssi_avg = '0;
  logic [7:0]  rssi_byte;
  logic        err_irq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  rfc_csr u_rfc_csr (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .memmap_miss(memmap_miss), .proto_err(proto_err), .phy_err(phy_err),
    .lp_clk(lp_clk), .lp_timer_rst(lp_timer_rst), .sleep_req(sleep_req),
    .sleep_exit(sleep_exit), .core_on_master(core_on_master),
    .rssi_peak(rssi_peak), .rssi_avg(rssi_avg), .rssi_byte(rssi_byte),
    .err_irq(err_irq)
  );

  // {write value, expected read-back}; no hardware events while walked (R9, R10)
  localparam logic [63:0] VEC [6] = '{
    {32'hFFFF_FFFF, 32'h01AE_7E0C},
    {32'h0000_0000, 32'h0000_0000},
    {32'h0000_1004, 32'h0000_1004},
    {32'h0020_2000, 32'h0020_2000},
    {32'hFE11_8030, 32'h0000_0000},
    {32'h0000_0004, 32'h0000_0004}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [31:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    chk("R1 reset word", rd_data, 32'h4);
    chk("R1 reset irq", {31'd0, err_irq}, 32'd0);
    chk("R1 reset rssi", {24'd0, rssi_byte}, 32'd0);

    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][63:32]);
      chk("R9/R10 table", rd_data, VEC[i][31:0]);
    end

    // R2 / R3 mapping-miss flag
    memmap_miss = 1'b1; step(1); memmap_miss = 1'b0;
    chk("R2 miss sets", rd_data, 32'h5);
    chk("R3 irq on", {31'd0, err_irq}, 32'd1);
    wr(32'h4);
    chk("R2 ack zero no effect", rd_data, 32'h5);
    wr(32'h6);
    chk("R2 ack clears", rd_data, 32'h4);
    chk("R3 irq off", {31'd0, err_irq}, 32'd0);
    wr(32'h0);
    memmap_miss = 1'b1; step(1); memmap_miss = 1'b0;
    chk("R2 masked miss", rd_data, 32'h1);
    chk("R3 masked irq", {31'd0, err_irq}, 32'd0);
    wr(32'h4);
    chk("R3 unmask irq", {31'd0, err_irq}, 32'd1);
    memmap_miss = 1'b1; wr(32'h6); memmap_miss = 1'b0;
    chk("R2 set beats ack", rd_data, 32'h5);
    wr(32'h6);
    chk("R2 final clear", rd_data, 32'h4);

    // R4 link error flag
    proto_err = 1'b1; phy_err = 1'b1; step(1); proto_err = 1'b0; phy_err = 1'b0;
    chk("R4 disabled sources", rd_data, 32'h4);
    chk("R3 no link irq", {31'd0, err_irq}, 32'd0);
    wr(32'h0080_0004);
    proto_err = 1'b1; step(1); proto_err = 1'b0;
    chk("R4 proto sets", rd_data, 32'h00C0_0004);
    chk("R3 link irq", {31'd0, err_irq}, 32'd1);
    wr(32'h00C0_0004);
    chk("R4 w1c", rd_data, 32'h0080_0004);
    phy_err = 1'b1; step(1); phy_err = 1'b0;
    chk("R4 phy blocked", rd_data, 32'h0080_0004);
    wr(32'h0100_0004);
    phy_err = 1'b1; step(1); phy_err = 1'b0;
    chk("R4 phy sets", rd_data, 32'h0140_0004);
    phy_err = 1'b1; wr(32'h0140_0004); phy_err = 1'b0;
    chk("R4 set beats clear", rd_data, 32'h0140_0004);
    wr(32'h0040_0004);
    chk("R4 cleared", rd_data, 32'h4);

    // R5 / R6 low-power clock monitor
    lp_clk = 1'b1; step(2);
    chk("R5 not yet", rd_data & 32'h80, 32'h0);
    step(1);
    chk("R5 edge latency", rd_data & 32'h80, 32'h80);
    wr(32'h84);
    chk("R5 write one ignored", rd_data & 32'h80, 32'h80);
    wr(32'h04);
    chk("R5 write zero clears", rd_data & 32'h80, 32'h0);
    lp_clk = 1'b0; step(4);
    lp_clk = 1'b1; step(2); wr(32'h04);
    chk("R5 edge beats clear", rd_data & 32'h80, 32'h80);
    wr(32'h04);
    lp_clk = 1'b0; step(4);
    lp_timer_rst = 1'b1; lp_clk = 1'b1; step(4);
    chk("R6 suppressed", rd_data & 32'h80, 32'h0);
    lp_clk = 1'b0; step(4); lp_timer_rst = 1'b0; step(1);

    // R7 power-down grant
    sleep_req = 1'b1; step(1); sleep_req = 1'b0;
    lp_clk = 1'b1; step(4);
    chk("R7 first edge no grant", rd_data & 32'h100, 32'h0);
    lp_clk = 1'b0; step(4);
    lp_clk = 1'b1; step(4);
    chk("R7 second edge grant", rd_data & 32'h100, 32'h100);
    wr(32'h04);
    chk("R7 sw cannot clear", rd_data & 32'h100, 32'h100);
    lp_clk = 1'b0; step(4);
    sleep_exit = 1'b1; step(1); sleep_exit = 1'b0;
    chk("R7 exit clears", rd_data & 32'h100, 32'h0);

    // R8 signal-strength byte
    rssi_peak = 10'h3FC; rssi_avg = 10'h155; step(1);
    chk("R8 peak", {24'd0, rssi_byte}, 32'hFF);
    wr(32'h0020_0004); step(1);
    chk("R8 average", {24'd0, rssi_byte}, 32'h55);
    rssi_avg = 10'h2A8; step(1);
    chk("R8 average follows", {24'd0, rssi_byte}, 32'hAA);
    wr(32'h04); step(1);
    chk("R8 back to peak", {24'd0, rssi_byte}, 32'hFF);

    // R9 clock status
    core_on_master = 1'b1; step(1);
    chk("R9 clk status high", rd_data & 32'h40, 32'h40);
    core_on_master = 1'b0; step(1);
    chk("R9 clk status low", rd_data & 32'h40, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule